// File: doc/BRIEF.md
# SPI Serial Memory Command and Protection Controller

This block is the slave-side control logic of a small SPI serial nonvolatile memory. It receives mode 0 traffic on a chip select, a serial clock and a serial data input. It decodes an 8-bit command, then any address and data bytes, and returns read data and status on a serial output. All SPI pins are sampled by the system clock, so the whole block runs in one clock domain. Each SCK high phase and each SCK low phase must last at least 8 system clocks. SO is driven low while the chip is deselected; the pad logic outside the block provides any tri-stating.

The block holds a status byte and a write-permission latch. It stores the array in on-chip flops, 256 bytes by default. A write or status update is first collected in full. It is committed only when chip select rises on a byte boundary. The commit starts an internal write cycle of a parameterised length, and a busy flag is raised for its duration. Writes pass through two checks. A block-guard field protects an upper region of the array. A guard-enable bit, together with an active-low hardware write-protect pin, can lock the status byte.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: guard-enable, flag, two stored timer bits, two block-guard bits, write-permission latch, busy. It reads 0x00 after reset. Command 0x05 returns it, refreshed on every byte, for as long as chip select stays low. It may be read at any time, busy or not.
- R2: Command, address and data move MSB first. SI is sampled on SCK rising edges, SO changes on SCK falling edges, and SO is 0 while chip select is high. SCK may pause for any time in mid-command without losing state.
- R3: Command 0x06 sets the latch (status bit 1). Command 0x04 clears both the latch and the flag (status bit 6). Command 0x00 sets the flag.
- R4: While the latch is 0, no array write and no status write is performed, and no write cycle starts.
- R5: Command 0x02 is followed by two address bytes. The low 8 bits of the address select the byte. The data bytes then fill consecutive locations within the 16-byte page, wrapping from offset 15 to offset 0.
- R6: An array write or status write is performed only if chip select rises after a whole number of bytes and after at least one data byte. Otherwise it has no effect and the latch keeps its value.
- R7: A performed write sets busy (status bit 0) for WCYC clocks. When busy falls, the latch is 0.
- R8: While busy is 1, every command other than 0x05 is ignored: it returns 0 on SO and changes no state.
- R9: Command 0x03 with a two-byte address returns consecutive bytes for as long as chip select stays low. The address wraps from 0xFF to 0x00.
- R10: The block-guard bits (status bits 3:2) protect part of the array: 00 protects nothing, 01 protects 0xC0 to 0xFF, 10 protects 0x80 to 0xFF, 11 protects the whole array. A write to a protected page is ignored and starts no cycle.
- R11: Command 0x01 followed by exactly one data byte updates status bits 7:2 from that byte and starts a write cycle. Bits 1:0 of the byte are ignored. Two or more data bytes cancel the update.
- R12: When guard-enable (bit 7) is 1 and wp_n is low, status writes are ignored. When wp_n is high, or guard-enable is 0, status writes are allowed. The pin has no effect on array writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| so | output | 1 | Serial data out, 0 while deselected |

## Verification
Two actions can land on the same cycle.

The first pair is the end of the internal write cycle and a status read in progress. The end of the cycle lowers busy and clears the latch on one edge. The bench polls the status byte back-to-back across the end of every write cycle. It requires that any byte showing busy 0 also shows the latch at 0.

The second pair is a command arriving inside the busy window. The bench issues a read, a flag set and a latch reset while busy. It requires zero read data and an unchanged status once the cycle ends.

// File: rtl/spi_eeprom_pkg.sv
// Shared command codes and sequencer state encoding for the SPI memory controller.
package spi_eeprom_pkg;
    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_FLAG_SET  = 8'h00;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;
    localparam logic [7:0] CMD_ARR_RD    = 8'h03;
    localparam logic [7:0] CMD_ARR_WR    = 8'h02;

    typedef enum logic [2:0] {
        SQ_OPCODE,
        SQ_ADDR_HI,
        SQ_ADDR_LO,
        SQ_READ,
        SQ_WRITE,
        SQ_STAT_RD,
        SQ_STAT_WR,
        SQ_DISCARD
    } seq_state_t;
endpackage

// File: rtl/spi_eeprom_link.sv
// Serial link: syncs the SPI pins into clk, assembles received bytes MSB first,
// and shifts tx bytes out on SCK falling edges.
// Assumes each SCK phase lasts at least 8 clk cycles.
module spi_eeprom_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic [7:0] tx_byte,
    output logic       sel,
    output logic       byte_rdy,
    output logic [7:0] rx_byte,
    output logic       cs_end,
    output logic       aligned,
    output logic       so
);
    logic [2:0] cs_sy;
    logic [2:0] sck_sy;
    logic [1:0] si_sy;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sck_rise;
    logic       sck_fall;

    assign sel      = ~cs_sy[1];
    assign cs_end   = cs_sy[1] & ~cs_sy[2];
    assign sck_rise = sck_sy[1] & ~sck_sy[2];
    assign sck_fall = ~sck_sy[1] & sck_sy[2];
    assign aligned  = (bit_cnt == 3'd0);
    assign so       = tx_sh[7];

    // Bring the asynchronous pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sy  <= 3'b111;
            sck_sy <= 3'b000;
            si_sy  <= 2'b00;
        end else begin
            cs_sy  <= {cs_sy[1:0], cs_n};
            sck_sy <= {sck_sy[1:0], sck};
            si_sy  <= {si_sy[0], si};
        end
    end

    // Shift in SI on rising SCK edges and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            byte_rdy <= 1'b0;
            rx_byte  <= '0;
        end else begin
            byte_rdy <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[5:0], si_sy[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_rdy <= 1'b1;
                    rx_byte  <= {rx_sh, si_sy[1]};
                end
            end
        end
    end

    // Drive SO: load a fresh byte on the first falling edge of a byte slot, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (!sel) begin
            tx_sh <= '0;
        end else if (sck_fall) begin
            tx_sh <= aligned ? tx_byte : {tx_sh[6:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_eeprom_store.sv
// Storage array: flop array with an asynchronous read port and a page-wide
// masked write port that commits a whole page buffer in one clock.
module spi_eeprom_store #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    input  logic                  commit,
    input  logic [AW-PW-1:0]      page,
    input  logic [(1<<PW)*8-1:0]  pdata,
    input  logic [(1<<PW)-1:0]    pmask
);
    localparam int DEPTH = 1 << AW;
    localparam int PD    = 1 << PW;

    logic [7:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int                SLOT = g % PD;
        localparam logic [AW-PW-1:0]  PG   = (AW-PW)'(g / PD);
        // Update one byte when its page commits and its slot was filled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (commit && page == PG && pmask[SLOT]) begin
                mem[g] <= pdata[SLOT*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_timer.sv
// Write-cycle timer: once started, stays busy for CYC clocks and pulses done
// in the last busy clock. Assumes start is only raised while idle.
module spi_eeprom_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(CYC - 1));

    // Count the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt  <= cnt + CW'(1);
        end
    end

    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy) else $error("start while busy");
endmodule

// File: rtl/spi_eeprom_ctrl.sv
// SPI memory controller top: command sequencer, status byte, write-permission
// latch and protection checks around the link, store and timer blocks.
// Assumes mode 0 traffic with SCK phases of at least 8 clk cycles.
module spi_eeprom_ctrl
    import spi_eeprom_pkg::*;
#(
    parameter int AW   = 8,
    parameter int PW   = 4,
    parameter int WCYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so
);
    localparam int PD = 1 << PW;
    localparam int GW = AW - PW;

    logic          sel, byte_rdy, cs_end, aligned;
    logic [7:0]    rx_byte, tx_byte, rd_data;
    seq_state_t    st;
    logic [7:0]    opc;
    logic [AW-1:0] addr;
    logic [PW-1:0] pidx;
    logic [7:0]    pbuf [PD];
    logic [PD-1:0] pmask;
    logic [PD*8-1:0] pdata;
    logic [5:0]    sr_pend;
    logic [1:0]    sr_cnt;
    logic          gen, flag, wel;
    logic [1:0]    tmr_bits, guard;
    logic          wip, tmr_done;
    logic [1:0]    wp_sy;
    logic          arr_fire, sr_fire, start;
    logic [7:0]    status;

    // Is the given page inside the region selected by the guard bits?
    function automatic logic in_guard(input logic [1:0] g, input logic [GW-1:0] pg);
        case (g)
            2'b00:   return 1'b0;
            2'b01:   return pg[GW-1] & pg[GW-2];
            2'b10:   return pg[GW-1];
            default: return 1'b1;
        endcase
    endfunction

    assign status   = {gen, flag, tmr_bits, guard, wel, wip};
    assign arr_fire = cs_end && aligned && st == SQ_WRITE && (|pmask) && wel
                      && !in_guard(guard, addr[AW-1:PW]);
    assign sr_fire  = cs_end && aligned && st == SQ_STAT_WR && sr_cnt == 2'd1 && wel
                      && (!gen || wp_sy[1]);
    assign start    = arr_fire || sr_fire;

    // Flatten the page buffer for the store's write port.
    always_comb begin
        for (int i = 0; i < PD; i++) pdata[i*8 +: 8] = pbuf[i];
    end

    // Choose the byte offered to the serial output.
    always_comb begin
        case (st)
            SQ_STAT_RD: tx_byte = status;
            SQ_READ:    tx_byte = rd_data;
            default:    tx_byte = 8'h00;
        endcase
    end

    // Synchronise the write-protect pin.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_sy <= 2'b11;
        else        wp_sy <= {wp_sy[0], wp_n};
    end

    // Command sequencer and status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_OPCODE;
            opc      <= '0;
            addr     <= '0;
            pidx     <= '0;
            pmask    <= '0;
            sr_pend  <= '0;
            sr_cnt   <= '0;
            gen      <= 1'b0;
            flag     <= 1'b0;
            tmr_bits <= '0;
            guard    <= '0;
            wel      <= 1'b0;
            for (int i = 0; i < PD; i++) pbuf[i] <= '0;
        end else begin
            if (tmr_done) wel <= 1'b0;
            if (sr_fire) {gen, flag, tmr_bits, guard} <= sr_pend;
            if (!sel) begin
                st <= SQ_OPCODE;
            end else if (byte_rdy) begin
                case (st)
                    SQ_OPCODE: begin
                        if (wip && rx_byte != CMD_STAT_RD) begin
                            st <= SQ_DISCARD;
                        end else begin
                            case (rx_byte)
                                CMD_LATCH_SET: begin wel <= 1'b1; st <= SQ_DISCARD; end
                                CMD_LATCH_CLR: begin wel <= 1'b0; flag <= 1'b0; st <= SQ_DISCARD; end
                                CMD_FLAG_SET:  begin flag <= 1'b1; st <= SQ_DISCARD; end
                                CMD_STAT_RD:   st <= SQ_STAT_RD;
                                CMD_STAT_WR:   begin sr_cnt <= '0; st <= SQ_STAT_WR; end
                                CMD_ARR_RD, CMD_ARR_WR: begin
                                    opc   <= rx_byte;
                                    pmask <= '0;
                                    st    <= SQ_ADDR_HI;
                                end
                                default:       st <= SQ_DISCARD;
                            endcase
                        end
                    end
                    SQ_ADDR_HI: st <= SQ_ADDR_LO;
                    SQ_ADDR_LO: begin
                        addr <= rx_byte[AW-1:0];
                        pidx <= rx_byte[PW-1:0];
                        st   <= (opc == CMD_ARR_RD) ? SQ_READ : SQ_WRITE;
                    end
                    SQ_READ: addr <= addr + AW'(1);
                    SQ_WRITE: begin
                        pbuf[pidx]  <= rx_byte;
                        pmask[pidx] <= 1'b1;
                        pidx        <= pidx + PW'(1);
                    end
                    SQ_STAT_WR: begin
                        sr_pend <= rx_byte[7:2];
                        if (sr_cnt != 2'd2) sr_cnt <= sr_cnt + 2'd1;
                    end
                    default: ;
                endcase
            end
        end
    end

    spi_eeprom_link u_link (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .tx_byte(tx_byte), .sel(sel), .byte_rdy(byte_rdy), .rx_byte(rx_byte),
        .cs_end(cs_end), .aligned(aligned), .so(so)
    );

    spi_eeprom_store #(.AW(AW), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
        .commit(arr_fire), .page(addr[AW-1:PW]), .pdata(pdata), .pmask(pmask)
    );

    spi_eeprom_timer #(.CYC(WCYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(tmr_done)
    );

    p_wel_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wel) else $error("write started without latch");
    p_wel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel) else $error("latch still set after cycle");
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !wip) else $error("latch set while busy");
    p_sr_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(guard) |-> $rose(wip)) else $error("guard bits changed outside a status write");
    p_sr_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sr_fire |-> (!gen || wp_sy[1])) else $error("status written while locked");
endmodule

// File: tb/spi_eeprom_ctrl_bench.sv
// Bench: behavioural model of the memory (arrays, flags) drives expectations;
// SO idle level is compared on every clock.
module spi_eeprom_ctrl_bench;
    localparam int WCYC = 2000;
    localparam int HALF = 8;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic so;
    int checks = 0, errors = 0, idle_bad = 0, hi_cnt = 0;
    bit finished = 0;

    logic [7:0] m_mem [256];
    bit m_gen, m_flag, m_wel, m_busy;
    logic [1:0] m_tb, m_guard;

    always #2 clk = ~clk;

    spi_eeprom_ctrl #(.WCYC(WCYC)) u_spi_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n), .so(so)
    );

    // R2: SO must sit at 0 while deselected (after sync settling) - every clock.
    always @(negedge clk) begin
        if (cs_n) hi_cnt++; else hi_cnt = 0;
        if (rst_n && hi_cnt > 5 && so !== 1'b0) idle_bad++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit m_prot(input int a);
        case (m_guard)
            2'b00: return 0;
            2'b01: return a >= 8'hC0;
            2'b10: return a >= 8'h80;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_sr(input bit busy);
        return {m_gen, m_flag, m_tb, m_guard, m_wel, busy};
    endfunction

    task automatic xfer(input bq_t tx, input int extra, input int pause_at, output bq_t rx);
        logic g;
        rx = {};
        cs_n = 1'b0;
        wt(HALF);
        foreach (tx[i]) begin
            logic [7:0] r = '0;
            for (int b = 7; b >= 0; b--) begin
                si = tx[i][b];
                wt(HALF);
                g = so;
                r = {r[6:0], g};
                sck = 1'b1;
                wt(HALF + ((i * 8 + 7 - b) == pause_at ? 300 : 0));
                sck = 1'b0;
            end
            rx.push_back(r);
        end
        for (int k = 0; k < extra; k++) begin
            si = 1'b1; wt(HALF); sck = 1'b1; wt(HALF); sck = 1'b0;
        end
        wt(HALF);
        cs_n = 1'b1;
        wt(2 * HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        bq_t t, r;
        t.push_back(op);
        xfer(t, 0, -1, r);
        if (!m_busy) begin
            if (op == 8'h06) m_wel = 1;
            if (op == 8'h04) begin m_wel = 0; m_flag = 0; end
            if (op == 8'h00) m_flag = 1;
        end
    endtask

    task automatic rdsr(output logic [7:0] s);
        bq_t t, r;
        t = '{8'h05, 8'h00};
        xfer(t, 0, -1, r);
        s = r[1];
    endtask

    task automatic wr(input int a, input bq_t d, input int extra);
        bq_t t, r;
        t = '{8'h02, 8'h00, 8'(a)};
        foreach (d[i]) t.push_back(d[i]);
        xfer(t, extra, -1, r);
        if (!m_busy && m_wel && extra == 0 && d.size() > 0 && !m_prot(a)) begin
            foreach (d[i]) m_mem[(a & 8'hF0) | ((a + i) & 8'h0F)] = d[i];
            m_busy = 1;
        end
    endtask

    task automatic rd(input int a, input int n, input int pause_at, output bq_t q);
        bq_t t, r;
        t = '{8'h03, 8'h00, 8'(a)};
        for (int i = 0; i < n; i++) t.push_back(8'h00);
        xfer(t, 0, pause_at, r);
        q = r[3:$];
    endtask

    task automatic wrsr(input logic [7:0] v, input int nbytes);
        bq_t t, r;
        t.push_back(8'h01);
        for (int i = 0; i < nbytes; i++) t.push_back(v);
        xfer(t, 0, -1, r);
        if (!m_busy && m_wel && nbytes == 1 && (!m_gen || wp_n)) begin
            {m_gen, m_flag, m_tb, m_guard} = v[7:2];
            m_busy = 1;
        end
    endtask

    // Poll status across the end of the write cycle.
    task automatic wait_idle(input string req);
        logic [7:0] s;
        bit first = 1;
        for (int p = 0; p < 40; p++) begin
            rdsr(s);
            if (first) chk({req, " busy seen"}, s[0], 1);
            first = 0;
            if (!s[0]) break;
        end
        m_busy = 0;
        m_wel = 0;
        chk({req, " R7 idle with latch clear"}, s, exp_sr(0));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] s;
        bq_t q;
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_tb = 0; m_guard = 0;
        wt(10);
        rst_n = 1'b1;
        wt(10);

        // R1 reset value
        rdsr(s); chk("R1 reset status", s, 8'h00);

        // R3 latch and flag commands
        cmd(8'h06); rdsr(s); chk("R3 latch set", s, exp_sr(0));
        cmd(8'h00); rdsr(s); chk("R3 flag set", s, 8'h42);
        cmd(8'h04); rdsr(s); chk("R3 latch+flag clear", s, 8'h00);

        // R4 write without latch
        wr(8'h20, '{8'hAA}, 0);
        rdsr(s); chk("R4 no cycle without latch", s, 8'h00);
        rd(8'h20, 1, -1, q); chk("R4 array unchanged", q[0], 8'h00);

        // R5 / R7 page write with wrap
        cmd(8'h06);
        wr(8'h1E, '{8'h11, 8'h22, 8'h33, 8'h44}, 0);
        wait_idle("R7 page write");
        rd(8'h10, 16, -1, q);
        for (int i = 0; i < 16; i++) chk("R5 page wrap", q[i], m_mem[8'h10 + i]);

        // R9 read wrap at top of array
        cmd(8'h06); wr(8'hFF, '{8'h5A}, 0); wait_idle("R7 top byte");
        cmd(8'h06); wr(8'h00, '{8'hC3}, 0); wait_idle("R7 bottom byte");
        rd(8'hFE, 3, -1, q);
        chk("R9 read FE", q[0], 8'h00);
        chk("R9 read FF", q[1], 8'h5A);
        chk("R9 wrap to 00", q[2], 8'hC3);

        // R6 partial byte and empty data
        cmd(8'h06);
        wr(8'h40, '{8'h77}, 3);
        rdsr(s); chk("R6 partial byte no cycle", s, 8'h02);
        wr(8'h40, '{}, 0);
        rdsr(s); chk("R6 no data no cycle", s, 8'h02);
        rd(8'h40, 1, -1, q); chk("R6 array unchanged", q[0], 8'h00);

        // R8 commands ignored while busy
        wr(8'h40, '{8'h99}, 0);
        rd(8'h40, 1, -1, q); chk("R8 read ignored when busy", q[0], 8'h00);
        cmd(8'h00);
        cmd(8'h04);
        rdsr(s); chk("R8 status during busy", s, 8'h03);
        wait_idle("R8 after busy");
        rd(8'h40, 1, -1, q); chk("R8 write landed", q[0], 8'h99);

        // R11 status write, low bits ignored, two bytes cancel
        cmd(8'h06); wrsr(8'h07, 1); wait_idle("R11 status write");
        rdsr(s); chk("R11 bits 7:2 only", s, 8'h04);
        cmd(8'h06); wrsr(8'h08, 2);
        rdsr(s); chk("R11 two bytes cancel", s, 8'h06);

        // R10 block guard
        wr(8'hC5, '{8'hAB}, 0);
        rdsr(s); chk("R10 upper quarter blocked", s, 8'h06);
        wr(8'h85, '{8'hCD}, 0); wait_idle("R10 unguarded write");
        rd(8'hC5, 1, -1, q); chk("R10 guarded byte", q[0], 8'h00);
        rd(8'h85, 1, -1, q); chk("R10 open byte", q[0], 8'hCD);
        cmd(8'h06); wrsr(8'h08, 1); wait_idle("R10 guard half");
        cmd(8'h06); wr(8'h86, '{8'h01}, 0);
        rdsr(s); chk("R10 upper half blocked", s, 8'h0A);
        wrsr(8'h0C, 1); wait_idle("R10 guard all");
        cmd(8'h06); wr(8'h05, '{8'h01}, 0);
        rdsr(s); chk("R10 whole array blocked", s, 8'h0E);
        wrsr(8'h00, 1); wait_idle("R10 guard off");
        rd(8'h05, 1, -1, q); chk("R10 byte 05 unchanged", q[0], 8'h00);

        // R12 guard-enable with hardware pin
        cmd(8'h06); wrsr(8'h80, 1); wait_idle("R12 set guard-enable");
        wp_n = 1'b0;
        cmd(8'h06); wrsr(8'h00, 1);
        rdsr(s); chk("R12 locked by pin", s, 8'h82);
        wr(8'h30, '{8'h5F}, 0); wait_idle("R12 array still writable");
        rd(8'h30, 1, -1, q); chk("R12 array write", q[0], 8'h5F);
        wp_n = 1'b1;
        cmd(8'h06); wrsr(8'h00, 1); wait_idle("R12 pin high unlocks");
        rdsr(s); chk("R12 guard-enable cleared", s, 8'h00);

        // R2 SCK pause mid-address
        rd(8'h1E, 1, 12, q); chk("R2 paused read", q[0], m_mem[8'h1E]);
        chk("R2 SO idle low", idle_bad, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule